// File: doc/BRIEF.md
# Serial ADC Frame Readout Controller

This block is the master side of a three-wire link to a single-channel 12-bit successive-approximation converter. The link has three lines: an active-low chip select, a serial clock and one serial data input. Each frame starts when the controller pulls chip select low. The controller then produces a fixed number of serial clocks, 14 or 16, and samples the data line on every rising clock edge. The converter changes its data on falling edges. The first two bits are framing zeros. The next 12 bits are the result, most significant bit first. In the 16-clock setting two more zero bits follow. The controller then releases chip select and holds it high for a quiet gap before the next frame may begin. This gap gives the converter the idle time it needs to acquire the next sample.

Three settings are applied to each frame: the serial clock half-period in system clocks, the frame length, and the quiet-gap length. They are taken at the moment chip select falls. A start pulse runs one frame. While the continuous input is held high, the controller starts a new frame as soon as each gap ends, so the link runs at the throughput set by the frame length and gap. Each result is delivered with a one-cycle valid strobe. A framing-error flag goes with it when a bit that should be zero was read as one.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset, cs_n_o and sclk_o are high, and busy_o and valid_o are low.
- R2: A start_i pulse sampled while idle drives cs_n_o low at the next clock edge. sclk_o first falls H system clocks later and then toggles every H clocks, where H is sclk_half_i and a value of 0 is treated as 1.
- R3: With long_frame_i = 1 a frame has N = 16 serial clocks, and with long_frame_i = 0 it has N = 14. cs_n_o stays low for exactly 2·H·N system clocks and sclk_o falls exactly N times within that window.
- R4: The data line is sampled when sclk_o rises. Serial bits 1 and 2 are framing zeros, and serial bits 3 to 14 form result_o with bit 11 first and bit 0 last.
- R5: valid_o is a one-cycle pulse in the first cycle after cs_n_o rises. result_o and frame_err_o change only when valid_o is asserted.
- R6: frame_err_o is 1 with the result when either framing bit 1 or 2 reads as one, or, in 16-clock frames, when trailing bit 15 or 16 reads as one. In 14-clock frames the line is not sampled after the last result bit, so its later value has no effect on frame_err_o.
- R7: After cs_n_o rises it stays high, and busy_o stays high, for G system clocks, where G = max(gap_len_i, MIN_GAP). sclk_o is high whenever cs_n_o is high.
- R8: If cont_i is high at the end of a gap, cs_n_o falls at that same edge and a new frame starts. Otherwise busy_o drops and the block goes idle.
- R9: Changes to long_frame_i, sclk_half_i or gap_len_i after a frame has started do not affect that frame or its gap.
- R10: A start_i pulse while busy_o is high is ignored and does not start an extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start one frame when idle |
| cont_i | input | 1 | Start the next frame automatically at the end of each gap |
| long_frame_i | input | 1 | 1: 16-clock frame, 0: 14-clock frame |
| sclk_half_i | input | 8 | Serial clock half-period in system clocks (0 means 1) |
| gap_len_i | input | 8 | Quiet gap in system clocks, raised to MIN_GAP if smaller |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | 12 | Last conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| frame_err_o | output | 1 | Framing bits were not all zero |
| busy_o | output | 1 | High from chip-select fall until the gap ends |

## Verification
The assertions assume that sdata_i changes only after a falling edge of sclk_o and stays steady through the next rising edge. This is how the converter behaves, and the bench's converter model drives a new bit only in reaction to an observed falling edge of sclk_o. They also assume the settings may change at any time, which is why the gap and bit-count properties compare against the values captured at the frame's start. The stimulus deliberately changes the settings in the middle of a frame and pulses start while busy, to confirm that this assumption holds.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int DIV_W     = 8;
    localparam int GAP_W     = 8;
    localparam int RES_W     = 12;
    localparam int LEAD_Z    = 2;
    localparam int TRAIL_Z   = 2;
    localparam int FRAME_MIN = LEAD_Z + RES_W;
    localparam int FRAME_MAX = LEAD_Z + RES_W + TRAIL_Z;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] half;
        logic [GAP_W-1:0] gap;
        logic             long_f;
    } rd_cfg_t;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             err;
    } rd_result_t;

    function automatic logic [CNT_W-1:0] frame_len(input logic long_f);
        return long_f ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MIN);
    endfunction

    function automatic rd_cfg_t cfg_fix(input rd_cfg_t raw, input logic [GAP_W-1:0] min_gap);
        rd_cfg_t c;
        c        = raw;
        c.half   = (raw.half == '0) ? DIV_W'(1) : raw.half;
        c.gap    = (raw.gap < min_gap) ? min_gap : raw.gap;
        return c;
    endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o
);

    logic [DIV_W-1:0] ph_cnt;
    logic             ph_end;

    assign ph_end = (ph_cnt == half_i - DIV_W'(1));
    assign rise_o = run_i && ph_end && !sclk_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_cnt <= '0;
            sclk_o <= 1'b1;
        end else if (!run_i) begin
            ph_cnt <= '0;
            sclk_o <= 1'b1;
        end else if (ph_end) begin
            ph_cnt <= '0;
            sclk_o <= ~sclk_o;
        end else begin
            ph_cnt <= ph_cnt + DIV_W'(1);
        end
    end

    // R7: the serial clock parks high once the frame stops running
    p_sclk_park_r7: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> sclk_o);

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cont_i,
    input  rd_cfg_t          cfg_i,
    input  logic             rise_i,
    output logic             run_o,
    output logic             cs_n_o,
    output logic             busy_o,
    output logic             last_o,
    output logic             long_o,
    output logic [DIV_W-1:0] half_o
);

    localparam logic [GAP_W-1:0] MIN_G = GAP_W'(MIN_GAP);

    rd_state_e        state;
    rd_cfg_t          cfg_q;
    rd_cfg_t          cfg_new;
    logic [CNT_W-1:0] bit_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic [CNT_W-1:0] n_bits;

    assign cfg_new = cfg_fix(cfg_i, MIN_G);
    assign n_bits  = frame_len(cfg_q.long_f);
    assign run_o   = (state == ST_FRAME);
    assign busy_o  = (state != ST_IDLE);
    assign last_o  = run_o && rise_i && (bit_cnt == n_bits - CNT_W'(1));
    assign long_o  = cfg_q.long_f;
    assign half_o  = cfg_q.half;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cs_n_o  <= 1'b1;
            bit_cnt <= '0;
            gap_cnt <= '0;
            cfg_q   <= '{half: DIV_W'(1), gap: MIN_G, long_f: 1'b0};
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q   <= cfg_new;
                        state   <= ST_FRAME;
                        cs_n_o  <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
                ST_FRAME: begin
                    if (last_o) begin
                        state   <= ST_GAP;
                        cs_n_o  <= 1'b1;
                        gap_cnt <= '0;
                    end else if (rise_i) begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == cfg_q.gap - GAP_W'(1)) begin
                        if (cont_i) begin
                            cfg_q   <= cfg_new;
                            state   <= ST_FRAME;
                            cs_n_o  <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1 / R8: chip select is never active while the block is idle
    p_cs_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> cs_n_o);

    // R3: the bit counter never passes the latched frame length
    p_bits_bound_r3: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < n_bits);

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic             last_i,
    input  logic             long_i,
    input  logic             sdata_i,
    output logic [RES_W-1:0] result_o,
    output logic             err_o,
    output logic             valid_o
);

    logic [FRAME_MAX-1:0] shreg;
    logic [FRAME_MAX-1:0] full;
    rd_result_t           dec;

    assign full = {shreg[FRAME_MAX-2:0], sdata_i};

    always_comb begin
        if (long_i) begin
            dec.data = full[TRAIL_Z +: RES_W];
            dec.err  = (|full[FRAME_MAX-1 -: LEAD_Z]) || (|full[TRAIL_Z-1:0]);
        end else begin
            dec.data = full[RES_W-1:0];
            dec.err  = |full[FRAME_MIN-1 -: LEAD_Z];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            result_o <= '0;
            err_o    <= 1'b0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= last_i;
            if (sample_i) shreg <= full;
            if (last_i) begin
                result_o <= dec.data;
                err_o    <= dec.err;
            end
        end
    end

    // R5: the delivered result only moves together with the strobe
    p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(result_o) && $stable(err_o)));

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int MIN_GAP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             long_frame_i,
    input  logic [7:0]       sclk_half_i,
    input  logic [7:0]       gap_len_i,
    input  logic             sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [11:0]      result_o,
    output logic             valid_o,
    output logic             frame_err_o,
    output logic             busy_o
);

    rd_cfg_t          cfg_raw;
    logic             run;
    logic             rise;
    logic             last;
    logic             long_q;
    logic [DIV_W-1:0] half_q;

    assign cfg_raw = '{half: sclk_half_i, gap: gap_len_i, long_f: long_frame_i};

    adc_rd_seq #(.MIN_GAP(MIN_GAP)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cont_i  (cont_i),
        .cfg_i   (cfg_raw),
        .rise_i  (rise),
        .run_o   (run),
        .cs_n_o  (cs_n_o),
        .busy_o  (busy_o),
        .last_o  (last),
        .long_o  (long_q),
        .half_o  (half_q)
    );

    adc_rd_sclk_gen sclk_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .half_i (half_q),
        .sclk_o (sclk_o),
        .rise_o (rise)
    );

    adc_rd_capture cap_i (
        .clk      (clk),
        .rst      (rst),
        .sample_i (rise),
        .last_i   (last),
        .long_i   (long_q),
        .sdata_i  (sdata_i),
        .result_o (result_o),
        .err_o    (frame_err_o),
        .valid_o  (valid_o)
    );

    // Gap-length watch for the quiet-interval property
    logic [GAP_W:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst)                    hi_run <= '0;
        else if (cs_n_o && busy_o)  hi_run <= hi_run + (GAP_W+1)'(1);
        else                        hi_run <= '0;
    end

    // R7: a frame that follows a gap never starts before MIN_GAP quiet cycles
    p_gap_min_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n_o) && hi_run != '0) |-> hi_run >= (GAP_W+1)'(MIN_GAP));

    // R7: serial clock is high whenever chip select is inactive
    p_sclk_high_r7: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sclk_o);

    // R5: the strobe appears only in the cycle chip select has just risen
    p_valid_edge_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o));

endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [11:0] res;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic        long_frame_i = 1'b0;
    logic [7:0]  sclk_half_i = 8'd1;
    logic [7:0]  gap_len_i = 8'd2;
    logic        sdata_i = 1'b1;
    logic        cs_n_o, sclk_o, valid_o, frame_err_o, busy_o;
    logic [11:0] result_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_reader dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i),
        .long_frame_i(long_frame_i), .sclk_half_i(sclk_half_i),
        .gap_len_i(gap_len_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .result_o(result_o), .valid_o(valid_o),
        .frame_err_o(frame_err_o), .busy_o(busy_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Converter model: new bit after each falling serial clock edge
    logic [15:0] tx_q[$];
    logic [15:0] cur_tx = '0;
    int          k = 0;

    always @(negedge cs_n_o) begin
        cur_tx = (tx_q.size() != 0) ? tx_q.pop_front() : 16'h0;
        k = 0;
    end
    always @(negedge sclk_o) begin
        if (!cs_n_o && k < 16) begin
            sdata_i <= cur_tx[15-k];
            k++;
        end
    end
    always @(posedge cs_n_o) sdata_i <= 1'b1;

    // Scoreboard and frame-shape monitor
    exp_t exp_q[$];
    int exp_low = 0, exp_n = 0, exp_h = 0, exp_gap = 0;
    int vcnt = 0, low_cnt = 0, fall_cnt = 0, first_fall = 0, gap_cnt = 0, sclk_bad = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) begin
                vcnt++;
                chk(!prev_valid && cs_n_o && !prev_cs, "R5 strobe", int'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(result_o == e.res, {e.tag, " result"}, int'(result_o), int'(e.res));
                    chk(frame_err_o == e.err, {e.tag, " frame_err"}, int'(frame_err_o), int'(e.err));
                end
            end
            if (!cs_n_o) begin
                low_cnt++;
                if (prev_sclk && !sclk_o) begin
                    fall_cnt++;
                    if (fall_cnt == 1) first_fall = low_cnt;
                end
            end
            if (cs_n_o && !prev_cs) begin
                chk(low_cnt == exp_low, "R3 cs low cycles", low_cnt, exp_low);
                chk(fall_cnt == exp_n, "R3 sclk count", fall_cnt, exp_n);
                chk(first_fall == exp_h + 1, "R2 first sclk fall", first_fall, exp_h + 1);
                low_cnt = 0; fall_cnt = 0; first_fall = 0;
            end
            if (busy_o && cs_n_o) gap_cnt++;
            else if (gap_cnt != 0) begin
                chk(gap_cnt == exp_gap, "R7 quiet gap", gap_cnt, exp_gap);
                gap_cnt = 0;
            end
            if (cs_n_o && !sclk_o) sclk_bad++;
            prev_cs = cs_n_o; prev_sclk = sclk_o; prev_valid = valid_o;
        end
    end

    task automatic set_cfg(input bit lf, input int h, input int g);
        long_frame_i = lf; sclk_half_i = 8'(h); gap_len_i = 8'(g);
        exp_h   = (h == 0) ? 1 : h;
        exp_n   = lf ? 16 : 14;
        exp_low = 2 * exp_h * exp_n;
        exp_gap = (g < 2) ? 2 : g;
    endtask

    task automatic queue_frame(input bit lf, input logic [1:0] lead, input logic [11:0] data,
                               input logic [1:0] trail, input string tag);
        exp_t e;
        tx_q.push_back({lead, data, trail});
        e.res = data;
        e.err = (lead != 2'b00) || (lf && trail != 2'b00);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(cs_n_o == 1'b0, "R2 cs falls after start", int'(cs_n_o), 0);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_frame(input bit lf, input int h, input int g, input logic [1:0] lead,
                            input logic [11:0] data, input logic [1:0] trail, input string tag);
        set_cfg(lf, h, g);
        queue_frame(lf, lead, data, trail, tag);
        pulse_start();
        wait_idle();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(cs_n_o && sclk_o, "R1 lines idle in reset", int'({cs_n_o, sclk_o}), 3);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n_o && sclk_o && !busy_o && !valid_o, "R1 reset state",
            int'({cs_n_o, sclk_o, busy_o, valid_o}), 12);

        // R3 R4: short and long frames, assorted patterns and half-periods
        do_frame(1'b0, 2, 3, 2'b00, 12'hA5C, 2'b00, "R4 short");
        do_frame(1'b1, 1, 2, 2'b00, 12'h3F1, 2'b00, "R4 long");
        do_frame(1'b1, 3, 5, 2'b00, 12'hFFF, 2'b00, "R4 all ones");
        do_frame(1'b0, 1, 4, 2'b00, 12'h000, 2'b00, "R4 all zeros");
        do_frame(1'b0, 4, 2, 2'b00, 12'h801, 2'b00, "R4 msb lsb");

        // R6: framing error detection and the unsampled tail of short frames
        do_frame(1'b0, 1, 2, 2'b00, 12'h123, 2'b11, "R6 short tail ignored");
        do_frame(1'b1, 1, 2, 2'b00, 12'h456, 2'b01, "R6 long trailing one");
        do_frame(1'b0, 2, 2, 2'b10, 12'h789, 2'b00, "R6 leading one");
        do_frame(1'b1, 2, 3, 2'b01, 12'hABC, 2'b00, "R6 leading one long");

        // R2 R7: zero half-period and zero gap are clamped
        do_frame(1'b1, 0, 0, 2'b00, 12'h5A5, 2'b00, "R2 half zero");

        // R8: continuous run of three frames, then stop
        begin
            int base;
            base = vcnt;
            set_cfg(1'b0, 1, 3);
            queue_frame(1'b0, 2'b00, 12'h111, 2'b00, "R8 cont 1");
            queue_frame(1'b0, 2'b00, 12'hEEE, 2'b00, "R8 cont 2");
            queue_frame(1'b0, 2'b01, 12'h0F0, 2'b00, "R8 cont 3");
            cont_i = 1'b1;
            pulse_start();
            while (vcnt < base + 3) @(negedge clk);
            cont_i = 1'b0;
            wait_idle();
            repeat (30) @(negedge clk);
            chk(vcnt == base + 3 && !busy_o, "R8 stops after cont drops", vcnt - base, 3);
        end

        // R9: settings changed mid-frame do not affect the running frame
        set_cfg(1'b0, 2, 3);
        queue_frame(1'b0, 2'b00, 12'h6C3, 2'b11, "R9 latched cfg");
        pulse_start();
        repeat (6) @(negedge clk);
        long_frame_i = 1'b1; sclk_half_i = 8'd4; gap_len_i = 8'd9;
        wait_idle();

        // R10: start pulses while busy are ignored
        begin
            int base;
            base = vcnt;
            set_cfg(1'b1, 2, 6);
            queue_frame(1'b1, 2'b00, 12'h2D4, 2'b00, "R10 single");
            pulse_start();
            repeat (10) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
            while (!cs_n_o) @(negedge clk);
            @(negedge clk) start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
            wait_idle();
            repeat (40) @(negedge clk);
            chk(vcnt == base + 1 && !busy_o, "R10 one frame only", vcnt - base, 1);
        end

        chk(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);
        chk(sclk_bad == 0, "R7 sclk high while deselected", sclk_bad, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule